// File: doc/BRIEF.md
# Character Display Parallel Bus Engine

This block is the host side of an 8-bit parallel character-display bus with a register-select line, a read/write line and an enable strobe. A client hands it one access at a time over a valid/ready handshake: register select, direction and a write byte. The engine then drives the select and direction lines, drives or releases the data bus, and pulses the enable strobe. Every bus phase lasts a whole number of system clocks. Each phase length comes from a nanosecond minimum, converted at the given clock period and rounded up.

Reads release the bus for the whole access. The bus is sampled once the data-delay interval after the enable rise has passed, and the byte is returned with a one-cycle response pulse. A poll request runs status reads over and over until bit 7 (the busy flag) comes back clear. It gives up after a set number of reads, and the response then carries a timeout flag.

The controller uses six states:
- ST_IDLE: ready is high.
- ST_SETUP: the lines settle before the enable rise.
- ST_EHIGH: the enable strobe is high.
- ST_HOLD: the lines are held after the enable fall.
- ST_RECOVER: the rest of the minimum enable cycle.
- ST_DONE: the response pulse.

Its transitions are:
- ST_IDLE to ST_SETUP when a request is accepted.
- ST_SETUP to ST_EHIGH, ST_EHIGH to ST_HOLD and ST_HOLD to ST_RECOVER, each when the phase counter expires.
- ST_RECOVER back to ST_SETUP for another poll read while the busy bit is set and the read limit is not reached.
- ST_RECOVER to ST_DONE otherwise.
- ST_DONE to ST_IDLE unconditionally.

Top module: `lcd_bus_engine`

## Requirements
- R1: A plain access drives lcd_rs from req_rs and lcd_rw from req_rw for the whole access. lcd_rs=1 selects display data and 0 selects the instruction/status register. lcd_rw=1 means read and 0 means write.
- R2: Each enable pulse stays high for exactly EH clocks. EH is the largest of: ceil(T_PW_NS/CLK_PERIOD_NS), ceil(T_DSW_NS/CLK_PERIOD_NS), and ceil(T_DDR_NS/CLK_PERIOD_NS)+1. The default is 18 clocks at 8 ns.
- R3: Successive enable rises within one access are at least ceil(T_CYC_NS/CLK_PERIOD_NS) clocks apart (150 at defaults). A single plain access raises rsp_valid exactly that many clocks plus one after the accepting edge (151 at defaults).
- R4: lcd_rs and lcd_rw are unchanged for at least one clock before the enable rises. They are also held for HOLD = max(1, ceil(T_AH_NS/period), ceil(T_DH_NS/period)) clocks after it falls (2 at defaults).
- R5: On writes, lcd_db_oe=1 and lcd_db_out carries the byte from the setup phase through HOLD clocks after the enable fall. At every other time, and for all reads, lcd_db_oe=0.
- R6: A read samples lcd_db_in at the end of enable-high clock number ceil(T_DDR_NS/period), counting from 0. It returns that byte on rsp_rdata while rsp_valid is high for one clock. A write returns rsp_rdata=0.
- R7: req_ready is high only in ST_IDLE. A request presented while req_ready is low has no effect: it causes no enable pulse and no bus write.
- R8: A poll request ignores req_rs and req_rw, and forces lcd_rs=0 and lcd_rw=1. It repeats status reads until the sampled bit 7 is 0, then returns that last status byte (bit 7 busy, bits 6..0 address) with rsp_timeout=0.
- R9: If bit 7 is still 1 after MAX_POLLS poll reads, the engine stops and returns the last status byte with rsp_timeout=1. rsp_timeout is only ever high together with rsp_valid.
- R10: While reset is held and just after it: lcd_e=0, lcd_db_oe=0, lcd_rw=1, req_ready=1 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle |
| req_rs | input | 1 | Register select for a plain access (1 data, 0 instruction/status) |
| req_rw | input | 1 | Direction for a plain access (1 read, 0 write) |
| req_poll | input | 1 | Run the busy poll instead of a plain access |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte read (0 after a write) |
| rsp_timeout | output | 1 | Poll gave up with busy still set |
| lcd_rs | output | 1 | Bus register-select line |
| lcd_rw | output | 1 | Bus read/write line |
| lcd_e | output | 1 | Bus enable strobe |
| lcd_db_out | output | 8 | Data driven onto the bus |
| lcd_db_oe | output | 1 | Output enable for lcd_db_out |
| lcd_db_in | input | 8 | Data read from the bus |

## Verification
A phase counter that expires early or late changes the enable width or the spacing between enable rises. That shows up at the very next enable edge, and a bench counting clocks at the pins catches it within one access. A wrong read sample point is exposed by the bench's bus model: it drives the inverted byte until the data-delay time has passed, so an early sample returns a wrong rsp_rdata on that access. A broken poll decision shows in the number of enable pulses and in rsp_timeout at the end of the same poll.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_EHIGH,
        ST_HOLD,
        ST_RECOVER,
        ST_DONE
    } bus_state_e;

    // Round a nanosecond interval up to whole clock periods.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    assign last = (cnt == (len - {{(CNT_W-1){1'b0}}, 1'b1}));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (!last) begin
            cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/lcd_poll_counter.sv
module lcd_poll_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic reached
);

    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] reads_q;

    assign reached = (reads_q >= W'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reads_q <= '0;
        end else if (clear) begin
            reads_q <= '0;
        end else if (bump && !reached) begin
            reads_q <= reads_q + {{(W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
    import lcd_bus_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_AS_NS       = 0,
    parameter int T_PW_NS       = 140,
    parameter int T_CYC_NS      = 1200,
    parameter int T_AH_NS       = 10,
    parameter int T_DSW_NS      = 40,
    parameter int T_DH_NS       = 10,
    parameter int T_DDR_NS      = 100,
    parameter int MAX_POLLS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_rs,
    input  logic       req_rw,
    input  logic       req_poll,
    input  logic [7:0] req_wdata,
    output logic       rsp_valid,
    output logic [7:0] rsp_rdata,
    output logic       rsp_timeout,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] lcd_db_out,
    output logic       lcd_db_oe,
    input  logic [7:0] lcd_db_in
);

    localparam int unsigned P        = CLK_PERIOD_NS;
    localparam int unsigned SETUP_CYC = max2(1, ns_to_cyc(T_AS_NS, P));
    localparam int unsigned DDR_CYC   = ns_to_cyc(T_DDR_NS, P);
    localparam int unsigned EH_CYC    = max2(max2(ns_to_cyc(T_PW_NS, P), ns_to_cyc(T_DSW_NS, P)),
                                             DDR_CYC + 1);
    localparam int unsigned HOLD_CYC  = max2(1, max2(ns_to_cyc(T_AH_NS, P), ns_to_cyc(T_DH_NS, P)));
    localparam int unsigned CYC_CYC   = ns_to_cyc(T_CYC_NS, P);
    localparam int unsigned BUSY_SUM  = SETUP_CYC + EH_CYC + HOLD_CYC;
    localparam int unsigned REC_CYC   = (CYC_CYC > BUSY_SUM) ? (CYC_CYC - BUSY_SUM) : 1;
    localparam int unsigned LEN_MAX   = max2(max2(SETUP_CYC, EH_CYC), max2(HOLD_CYC, REC_CYC));
    localparam int          CNT_W     = $clog2(LEN_MAX + 1);

    bus_state_e state_q, state_nx;

    logic             accept;
    logic             restart;
    logic [CNT_W-1:0] phase_len;
    logic [CNT_W-1:0] phase_cnt;
    logic             phase_last;
    logic             poll_limit;
    logic             poll_bump;

    logic       rs_q, rw_q, poll_q, timeout_q;
    logic [7:0] wdata_q, rdata_q;
    logic       rw_eff;
    logic       sample_now;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_ready && req_valid;
    assign restart    = (state_nx != state_q);
    assign sample_now = (state_q == ST_EHIGH) && (phase_cnt == CNT_W'(DDR_CYC)) && rw_q;
    assign poll_bump  = poll_q && (state_q == ST_HOLD) && phase_last;
    assign rw_eff     = accept ? (req_poll | req_rw) : rw_q;

    always_comb begin
        unique case (state_q)
            ST_SETUP:   phase_len = CNT_W'(SETUP_CYC);
            ST_EHIGH:   phase_len = CNT_W'(EH_CYC);
            ST_HOLD:    phase_len = CNT_W'(HOLD_CYC);
            ST_RECOVER: phase_len = CNT_W'(REC_CYC);
            default:    phase_len = CNT_W'(1);
        endcase
    end

    lcd_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .len     (phase_len),
        .cnt     (phase_cnt),
        .last    (phase_last)
    );

    lcd_poll_counter #(.LIMIT(MAX_POLLS)) u_polls (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .bump    (poll_bump),
        .reached (poll_limit)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid)  state_nx = ST_SETUP;
            ST_SETUP:   if (phase_last) state_nx = ST_EHIGH;
            ST_EHIGH:   if (phase_last) state_nx = ST_HOLD;
            ST_HOLD:    if (phase_last) state_nx = ST_RECOVER;
            ST_RECOVER: if (phase_last) begin
                            if (poll_q && rdata_q[7] && !poll_limit) state_nx = ST_SETUP;
                            else                                     state_nx = ST_DONE;
                        end
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register and access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rs_q      <= 1'b0;
            rw_q      <= 1'b1;
            poll_q    <= 1'b0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            timeout_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (accept) begin
                rs_q      <= req_poll ? 1'b0 : req_rs;
                rw_q      <= req_poll | req_rw;
                poll_q    <= req_poll;
                wdata_q   <= req_wdata;
                rdata_q   <= '0;
                timeout_q <= 1'b0;
            end else begin
                if (sample_now) rdata_q <= lcd_db_in;
                if (state_q == ST_RECOVER && state_nx == ST_DONE)
                    timeout_q <= poll_q && rdata_q[7];
            end
        end
    end

    // Registered bus and response outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcd_e     <= 1'b0;
            lcd_db_oe <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            lcd_e     <= (state_nx == ST_EHIGH);
            lcd_db_oe <= !rw_eff && ((state_nx == ST_SETUP) || (state_nx == ST_EHIGH) ||
                                     (state_nx == ST_HOLD));
            rsp_valid <= (state_nx == ST_DONE);
        end
    end

    assign lcd_rs      = rs_q;
    assign lcd_rw      = rw_q;
    assign lcd_db_out  = wdata_q;
    assign rsp_rdata   = rdata_q;
    assign rsp_timeout = timeout_q && rsp_valid;

endmodule

// File: rtl/lcd_bus_checker.sv
module lcd_bus_checker #(
    parameter int EH_MIN = 18
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_timeout,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_e,
    input logic       lcd_db_oe,
    input logic [7:0] lcd_db_out
);

    logic [15:0] ehigh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ehigh_q <= '0;
        else if (lcd_e)  ehigh_q <= ehigh_q + 16'd1;
        else             ehigh_q <= '0;
    end

    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (ehigh_q >= 16'(EH_MIN)));

    assert_setup_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw)));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw)));

    assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> (lcd_db_oe == !lcd_rw));

    assert_write_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lcd_e) && !lcd_rw) |-> (lcd_db_oe && $stable(lcd_db_out)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!lcd_e && !lcd_db_oe));

    assert_single_response_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_timeout_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> rsp_valid);

endmodule

bind lcd_bus_engine lcd_bus_checker #(.EH_MIN(EH_CYC)) u_lcd_bus_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_timeout (rsp_timeout),
    .lcd_rs      (lcd_rs),
    .lcd_rw      (lcd_rw),
    .lcd_e       (lcd_e),
    .lcd_db_oe   (lcd_db_oe),
    .lcd_db_out  (lcd_db_out)
);

// File: tb/lcd_bus_engine_bench.sv
module lcd_bus_engine_bench;

    localparam int CLK_NS   = 8;
    localparam int PW_NS    = 140;
    localparam int CYC_NS   = 1200;
    localparam int AH_NS    = 10;
    localparam int DSW_NS   = 40;
    localparam int DH_NS    = 10;
    localparam int DDR_NS   = 100;
    localparam int NPOLL    = 4;

    localparam int DDR_EXP   = (DDR_NS + CLK_NS - 1) / CLK_NS;
    localparam int PW_C      = (PW_NS + CLK_NS - 1) / CLK_NS;
    localparam int DSW_C     = (DSW_NS + CLK_NS - 1) / CLK_NS;
    localparam int EH_A      = (PW_C > DSW_C) ? PW_C : DSW_C;
    localparam int EH_EXP    = (EH_A > DDR_EXP + 1) ? EH_A : DDR_EXP + 1;
    localparam int AH_C      = (AH_NS + CLK_NS - 1) / CLK_NS;
    localparam int DH_C      = (DH_NS + CLK_NS - 1) / CLK_NS;
    localparam int HOLD_A    = (AH_C > DH_C) ? AH_C : DH_C;
    localparam int HOLD_EXP  = (HOLD_A > 1) ? HOLD_A : 1;
    localparam int CYC_EXP   = (CYC_NS + CLK_NS - 1) / CLK_NS;
    localparam int LAT_EXP   = CYC_EXP + 1;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, req_rs, req_rw, req_poll;
    logic [7:0] req_wdata;
    logic       req_ready, rsp_valid, rsp_timeout;
    logic [7:0] rsp_rdata;
    logic       lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
    logic [7:0] lcd_db_out;
    logic [7:0] lcd_db_in;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bus model state
    int       ecnt = 0, since_rise = 0, hold_left = 0;
    bit       have_rise = 1'b0, e_prev = 1'b0, rs_prev = 1'b0, rw_prev = 1'b1, oe_prev = 1'b0;
    logic [7:0] db_prev = '0;
    bit       sn_rs, sn_rw, sn_oe;
    logic [7:0] sn_db;
    int       pulses = 0, wcount = 0, status_reads = 0, busy_k = 0;
    logic [7:0] last_w = '0;
    bit       last_wrs = 1'b0;
    logic [7:0] data_val = '0;
    logic [6:0] ac_val = '0;

    always #(CLK_NS/2) clk = ~clk;

    lcd_bus_engine #(
        .CLK_PERIOD_NS(CLK_NS), .T_AS_NS(0), .T_PW_NS(PW_NS), .T_CYC_NS(CYC_NS),
        .T_AH_NS(AH_NS), .T_DSW_NS(DSW_NS), .T_DH_NS(DH_NS), .T_DDR_NS(DDR_NS),
        .MAX_POLLS(NPOLL)
    ) u_lcd_bus_engine (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_rs(req_rs), .req_rw(req_rw),
        .req_poll(req_poll), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_db_out(lcd_db_out),
        .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Bus model: timing monitor and target device, evaluated on falling edges
    always @(negedge clk) begin
        logic [7:0] val;
        if (rst_n) begin
            if (lcd_e && !e_prev) begin
                check(lcd_rs == rs_prev && lcd_rw == rw_prev, "R4 setup stable", int'(lcd_rs), int'(rs_prev));
                check(lcd_db_oe == !lcd_rw, "R5 oe at rise", int'(lcd_db_oe), int'(!lcd_rw));
                if (have_rise && since_rise < CYC_EXP)
                    check(1'b0, "R3 rise spacing", since_rise, CYC_EXP);
                since_rise = 0;
                have_rise  = 1'b1;
            end
            if (lcd_e) begin
                ecnt++;
            end else if (e_prev) begin
                check(ecnt == EH_EXP, "R2 enable width", ecnt, EH_EXP);
                pulses++;
                sn_rs = rs_prev; sn_rw = rw_prev; sn_oe = oe_prev; sn_db = db_prev;
                hold_left = HOLD_EXP;
                if (!rw_prev) begin
                    wcount++;
                    last_w   = db_prev;
                    last_wrs = rs_prev;
                end else if (!rs_prev) begin
                    status_reads++;
                end
                ecnt = 0;
            end
            if (hold_left > 0 && !lcd_e) begin
                check(lcd_rs == sn_rs && lcd_rw == sn_rw && lcd_db_oe == sn_oe &&
                      (!sn_oe || lcd_db_out == sn_db), "R4 R5 hold", int'(lcd_db_out), int'(sn_db));
                hold_left--;
            end
            if (!lcd_e && !(hold_left > 0) && !e_prev && lcd_db_oe && !req_ready && lcd_rw)
                check(1'b0, "R5 oe on read", 1, 0);
            since_rise++;
        end
        val = lcd_rs ? data_val : {(status_reads < busy_k), ac_val};
        lcd_db_in = (lcd_e && (ecnt - 1) * CLK_NS >= DDR_NS) ? val : ~val;
        e_prev  = lcd_e;
        rs_prev = lcd_rs;
        rw_prev = lcd_rw;
        oe_prev = lcd_db_oe;
        db_prev = lcd_db_out;
    end

    task automatic do_op(input bit rs, input bit rw, input bit poll, input logic [7:0] wd,
                         input bit inject,
                         output logic [7:0] rd, output bit to, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_rs = rs; req_rw = rw; req_poll = poll; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 3000) begin
            if (inject && lat == 5) begin
                req_valid = 1'b1; req_rs = 1'b1; req_rw = 1'b0; req_poll = 1'b0; req_wdata = ~wd;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        rd = rsp_rdata;
        to = rsp_timeout;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        bit to;
        int lat, p0, w0, s0, exp_reads;
        logic [7:0] exp_rd;

        rst_n = 1'b0; req_valid = 1'b0; req_rs = 1'b0; req_rw = 1'b0; req_poll = 1'b0;
        req_wdata = '0; lcd_db_in = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(lcd_e == 1'b0 && lcd_db_oe == 1'b0, "R10 reset bus", int'(lcd_e), 0);
        check(lcd_rw == 1'b1, "R10 reset rw", int'(lcd_rw), 1);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R10 reset handshake", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && lcd_e == 1'b0, "R10 after reset", int'(req_ready), 1);

        // Write sweep over every byte, register select alternating (R1, R5, R6, R3)
        for (int i = 0; i < 256; i++) begin
            w0 = wcount;
            do_op(i[0], 1'b0, 1'b0, 8'(i), 1'b0, rd, to, lat);
            check(wcount == w0 + 1 && last_w == 8'(i), "R5 write byte", int'(last_w), i);
            check(last_wrs == i[0], "R1 write select", int'(last_wrs), int'(i[0]));
            check(rd == 8'h00, "R6 write returns zero", int'(rd), 0);
            if (i == 0 || i == 255)
                check(lat == LAT_EXP, "R3 access length", lat, LAT_EXP);
        end

        // Data read sweep (R6, R1)
        for (int i = 0; i < 64; i++) begin
            data_val = 8'(i * 37 + 5);
            w0 = wcount;
            do_op(1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, rd, to, lat);
            check(rd == data_val, "R6 read sample", int'(rd), int'(data_val));
            check(wcount == w0, "R1 read does not write", wcount, w0);
        end

        // Plain status read with busy set: one pulse only (R1, R8)
        ac_val = 7'h4E;
        busy_k = status_reads + 1;
        p0 = pulses;
        do_op(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, rd, to, lat);
        check(rd == 8'hCE, "R1 status byte", int'(rd), 8'hCE);
        check(pulses == p0 + 1 && !to, "R8 plain read no poll", pulses - p0, 1);

        // Poll sweep over busy lengths (R8, R9)
        for (int k = 0; k <= NPOLL + 1; k++) begin
            ac_val = 7'(k * 9 + 1);
            busy_k = status_reads + k;
            p0 = pulses; w0 = wcount; s0 = status_reads;
            do_op(1'b1, 1'b0, 1'b1, 8'h3C, 1'b0, rd, to, lat);
            exp_reads = (k < NPOLL) ? k + 1 : NPOLL;
            exp_rd    = {(k >= NPOLL), ac_val};
            check(pulses - p0 == exp_reads && status_reads - s0 == exp_reads,
                  "R8 poll read count", pulses - p0, exp_reads);
            check(wcount == w0, "R8 poll forces status read", wcount - w0, 0);
            check(rd == exp_rd, "R8 poll last status", int'(rd), int'(exp_rd));
            check(to == (k >= NPOLL), "R9 poll timeout", int'(to), int'(k >= NPOLL));
        end

        // Request while busy is ignored (R7)
        p0 = pulses; w0 = wcount;
        do_op(1'b1, 1'b0, 1'b0, 8'h5A, 1'b1, rd, to, lat);
        repeat (400) @(negedge clk);
        check(pulses == p0 + 1, "R7 ignored request pulses", pulses - p0, 1);
        check(wcount == w0 + 1 && last_w == 8'h5A, "R7 ignored request data", int'(last_w), 8'h5A);
        check(req_ready == 1'b1 && lcd_e == 1'b0, "R7 idle after", int'(req_ready), 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule